// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. A rising edge on the convert command starts a conversion. The block first holds or extends the sampling phase, then runs a binary search over the result code. On each step it presents a trial code to an external DAC and reads a single comparator bit back. The finished code is latched into an output register and can be read from a parallel bus that is released to high impedance while a conversion runs.

A static mode input picks how sampling ends. In direct hold mode the command edge itself closes acquisition, and bit decisions start on the next cycle. In timed mode the command edge starts an internal acquisition delay of a fixed number of cycles, and the search starts only when that delay has run out. A length input, captured with the command, picks a full conversion or a short one that resolves only the upper bits.

Top module: `sar_seq_top`

## Requirements
- R1: A synchronous active-low reset, taken at any time, including mid-conversion, leaves the block idle: `busy` low, `track` high and the latched result 0.
- R2: A full conversion makes the result equal to the largest code C for which the comparator reports input >= C. `cmp_in` = 1 means the analog input is at or above the level of `dac_code`. Bits are decided from the MSB down, one per cycle.
- R3: With `mode_direct` = 1, `busy` rises one clock after `cmd` is first seen high and stays high for exactly RES_BITS cycles (12). `track` is low for the whole of that time.
- R4: With `mode_direct` = 0, `busy` stays high for ACQ_CYCLES + RES_BITS cycles (26). `track` is high for the first ACQ_CYCLES (14) of those and low for the rest.
- R5: With `short_conv` = 1 at the command edge, only SHORT_BITS bits are decided (8 busy cycles in direct mode, 22 in timed mode). The upper 8 result bits match the input code, and the lower 4 are 0.
- R6: A rising edge of `cmd` while `busy` is high is ignored. The running conversion keeps its length and its result, and no second conversion follows it.
- R7: The latched result stays constant while `busy` is high. It takes the new code on the same edge where `busy` falls, so the first idle cycle already shows it.
- R8: `data_bus` carries the latched result and `bus_drive` is 1 only while `oe` = 1 and `busy` = 0. Otherwise `bus_drive` is 0 and the bus floats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 1 | Convert command; a rising edge starts a conversion |
| mode_direct | input | 1 | 1: command edge ends sampling; 0: timed acquisition delay |
| short_conv | input | 1 | 1: short conversion of SHORT_BITS bits, captured at the command edge |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |
| oe | input | 1 | Output enable for the result bus |
| dac_code | output | RES_BITS | Trial code to the external DAC |
| track | output | 1 | 1 while the front end samples, 0 while it holds |
| busy | output | 1 | Conversion in progress |
| bus_drive | output | 1 | 1 while the result bus is driven |
| data_bus | output | RES_BITS | Result bus, high impedance unless driven |

## Verification
The bench builds the block with RES_BITS = 12, SHORT_BITS = 8 and ACQ_CYCLES = 14. With these values the four busy lengths (12, 8, 26 and 22 cycles) are all different. A single count of busy cycles therefore shows whether the mode and the length were honoured. A 12-bit behavioural DAC and comparator make all-zero, all-ones and mid-scale neighbour codes reachable, along with the truncation of the low nibble in short conversions.

// File: rtl/sar_seq_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes nothing beyond a single clock domain.
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
// Phase controller: detects the command edge, runs the timed acquisition
// when requested and sequences the bit decisions of the search.
// Assumes mode_direct is static during a conversion; short_conv is captured
// at the command edge.
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int ACQ_CYCLES = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic mode_direct,
    input  logic short_conv,
    input  logic at_last,
    output logic busy,
    output logic track,
    output logic init_search,
    output logic step_search,
    output logic done,
    output logic short_q
);
    localparam int CNT_W = $clog2(ACQ_CYCLES + 1);
    localparam logic [CNT_W-1:0] ACQ_LOAD = CNT_W'(ACQ_CYCLES - 1);

    seq_state_t       state;
    logic             cmd_q;
    logic [CNT_W-1:0] acq_cnt;
    logic             start;

    // Command edge accepted only when idle.
    assign start = cmd && !cmd_q && (state == ST_IDLE);

    // Phase register, acquisition counter and captured length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cmd_q   <= 1'b0;
            acq_cnt <= '0;
            short_q <= 1'b0;
        end else begin
            cmd_q <= cmd;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        short_q <= short_conv;
                        if (mode_direct) begin
                            state <= ST_CONV;
                        end else begin
                            state   <= ST_ACQ;
                            acq_cnt <= ACQ_LOAD;
                        end
                    end
                end
                ST_ACQ: begin
                    if (acq_cnt == '0) begin
                        state <= ST_CONV;
                    end else begin
                        acq_cnt <= acq_cnt - CNT_W'(1);
                    end
                end
                ST_CONV: begin
                    if (at_last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Control strobes to the search register and status outputs.
    always_comb begin
        init_search = (start && mode_direct) ||
                      ((state == ST_ACQ) && (acq_cnt == '0));
        step_search = (state == ST_CONV);
        done        = step_search && at_last;
        busy        = (state != ST_IDLE);
        track       = (state != ST_CONV);
    end
endmodule

// File: rtl/sar_seq_search.sv
// Successive-approximation register: sets each trial bit, keeps or clears it
// from the comparator, and moves one bit down per step.
// Assumes cmp_in refers to the current trial code on dac_code.
module sar_seq_search #(
    parameter int RES_BITS   = 12,
    parameter int SHORT_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init,
    input  logic                step,
    input  logic                short_sel,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] trial,
    output logic [RES_BITS-1:0] resolved,
    output logic                at_last
);
    localparam int IDX_W = $clog2(RES_BITS);
    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(RES_BITS - 1);
    localparam logic [IDX_W-1:0] SHORT_IDX = IDX_W'(RES_BITS - SHORT_BITS);
    localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    stop_idx;
    logic [RES_BITS-1:0] next_trial;

    // Final bit position for the selected length and the decided word.
    always_comb begin
        stop_idx    = short_sel ? SHORT_IDX : '0;
        at_last     = (idx == stop_idx);
        resolved    = trial;
        resolved[idx] = cmp_in;
        next_trial  = resolved;
        if (!at_last) begin
            next_trial[idx - IDX_W'(1)] = 1'b1;
        end
    end

    // Trial code and bit pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial <= '0;
            idx   <= '0;
        end else if (init) begin
            trial <= MSB_ONE;
            idx   <= TOP_IDX;
        end else if (step) begin
            trial <= next_trial;
            if (!at_last) begin
                idx <= idx - IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/sar_seq_outbuf.sv
// Result holding register and bus-enable decision.
// Assumes load is a single-cycle strobe at the final bit decision.
module sar_seq_outbuf #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RES_BITS-1:0] din,
    input  logic                oe,
    input  logic                busy,
    output logic [RES_BITS-1:0] result,
    output logic                drive
);
    // Latch the finished code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (load) begin
            result <= din;
        end
    end

    // Bus is driven only when enabled and idle.
    assign drive = oe && !busy;
endmodule

// File: rtl/sar_seq_top.sv
// Top of the conversion sequencer: phase controller, search register and
// result buffer, with the three-state result bus.
// Assumes an external DAC and comparator close the loop within one cycle.
module sar_seq_top #(
    parameter int RES_BITS   = 12,
    parameter int SHORT_BITS = 8,
    parameter int ACQ_CYCLES = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd,
    input  logic                mode_direct,
    input  logic                short_conv,
    input  logic                cmp_in,
    input  logic                oe,
    output logic [RES_BITS-1:0] dac_code,
    output logic                track,
    output logic                busy,
    output logic                bus_drive,
    output logic [RES_BITS-1:0] data_bus
);
    logic                init_search;
    logic                step_search;
    logic                done;
    logic                short_q;
    logic                at_last;
    logic [RES_BITS-1:0] resolved;
    logic [RES_BITS-1:0] result;

    sar_seq_ctrl #(
        .ACQ_CYCLES (ACQ_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .mode_direct (mode_direct),
        .short_conv  (short_conv),
        .at_last     (at_last),
        .busy        (busy),
        .track       (track),
        .init_search (init_search),
        .step_search (step_search),
        .done        (done),
        .short_q     (short_q)
    );

    sar_seq_search #(
        .RES_BITS   (RES_BITS),
        .SHORT_BITS (SHORT_BITS)
    ) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (init_search),
        .step      (step_search),
        .short_sel (short_q),
        .cmp_in    (cmp_in),
        .trial     (dac_code),
        .resolved  (resolved),
        .at_last   (at_last)
    );

    sar_seq_outbuf #(
        .RES_BITS (RES_BITS)
    ) u_outbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (done),
        .din    (resolved),
        .oe     (oe),
        .busy   (busy),
        .result (result),
        .drive  (bus_drive)
    );

    // Three-state result bus.
    assign data_bus = bus_drive ? result : {RES_BITS{1'bz}};
endmodule

// File: rtl/sar_seq_chk.sv
// Property checker for the sequencer, bound into every top instance.
module sar_seq_chk #(
    parameter int RES_BITS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd,
    input logic                mode_direct,
    input logic                busy,
    input logic                track,
    input logic [RES_BITS-1:0] result
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && track && (result == '0)));

    // R3
    busy_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd));

    // R3
    direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_direct && busy) |-> !track);

    // R4
    timed_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_direct && $rose(busy)) |-> track);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result));
endmodule

bind sar_seq_top sar_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .mode_direct (mode_direct),
    .busy        (busy),
    .track       (track),
    .result      (result)
);

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
    localparam int W   = 12;
    localparam int ACQ = 14;
    // entry: mode_direct, short, vin, expected result, busy cycles, track cycles
    localparam int NV = 8;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 1'b0, 12'h000, 12'h000, 6'd12, 5'd0},
        {1'b1, 1'b0, 12'hFFF, 12'hFFF, 6'd12, 5'd0},
        {1'b1, 1'b0, 12'hA5C, 12'hA5C, 6'd12, 5'd0},
        {1'b0, 1'b0, 12'h7FF, 12'h7FF, 6'd26, 5'd14},
        {1'b0, 1'b0, 12'h800, 12'h800, 6'd26, 5'd14},
        {1'b1, 1'b1, 12'hABC, 12'hAB0, 6'd8,  5'd0},
        {1'b0, 1'b1, 12'h00F, 12'h000, 6'd22, 5'd14},
        {1'b1, 1'b1, 12'hFFF, 12'hFF0, 6'd8,  5'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd = 1'b0;
    logic         mode_direct = 1'b1;
    logic         short_conv = 1'b0;
    logic         oe = 1'b1;
    logic [W-1:0] vin = '0;
    logic         cmp_in;
    logic [W-1:0] dac_code;
    logic         track;
    logic         busy;
    logic         bus_drive;
    logic [W-1:0] data_bus;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // Behavioural DAC and comparator.
    assign cmp_in = (vin >= dac_code);

    sar_seq_top #(.RES_BITS(W), .SHORT_BITS(8), .ACQ_CYCLES(ACQ)) i_sar_seq_top (
        .clk (clk), .rst_n (rst_n), .cmd (cmd), .mode_direct (mode_direct),
        .short_conv (short_conv), .cmp_in (cmp_in), .oe (oe),
        .dac_code (dac_code), .track (track), .busy (busy),
        .bus_drive (bus_drive), .data_bus (data_bus)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Runs one conversion from a negedge; returns at the first idle negedge.
    task automatic run_conv(input logic md, input logic sh, input logic [W-1:0] v,
                            input bit retrigger, output int bcnt, output int tcnt,
                            output int drv_bad);
        bcnt = 0; tcnt = 0; drv_bad = 0;
        mode_direct = md; short_conv = sh; vin = v; cmd = 1'b1;
        @(negedge clk);
        while (busy) begin
            bcnt++;
            if (track) tcnt++;
            if (bus_drive) drv_bad++;
            if (retrigger && bcnt == 4) cmd = 1'b0;
            if (retrigger && bcnt == 5) cmd = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bc, tc, db;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 track", track, 1);
        check("R8 drive idle", bus_drive, 1);
        check("R1 result", data_bus, 0);

        for (int i = 0; i < NV; i++) begin
            run_conv(VEC[i][36], VEC[i][35], VEC[i][34:23], 1'b0, bc, tc, db);
            check(VEC[i][35] ? "R5 busy length" : (VEC[i][36] ? "R3 busy length" : "R4 busy length"),
                  bc, int'(VEC[i][10:5]));
            check(VEC[i][36] ? "R3 track" : "R4 track", tc, int'(VEC[i][4:0]));
            check("R8 released while busy", db, 0);
            // R7: the first idle cycle already shows the new code
            check("R7 drive after", bus_drive, 1);
            check(VEC[i][35] ? "R5 result" : "R2 result", data_bus, int'(VEC[i][22:11]));
            cmd = 1'b0;
            @(negedge clk);
        end

        // R6 retrigger during busy is ignored
        run_conv(1'b1, 1'b0, 12'h123, 1'b1, bc, tc, db);
        check("R6 busy length", bc, 12);
        check("R6 result", data_bus, 'h123);
        repeat (3) @(negedge clk);
        check("R6 no second run", busy, 0);
        cmd = 1'b0;
        @(negedge clk);

        // R8 oe low releases the bus while idle
        oe = 1'b0;
        @(negedge clk);
        check("R8 oe low", bus_drive, 0);
        oe = 1'b1;
        @(negedge clk);
        check("R8 oe high", data_bus, 'h123);

        // R1 reset in the middle of a timed conversion
        mode_direct = 1'b0; short_conv = 1'b0; vin = 12'h456; cmd = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b0; cmd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid busy", busy, 0);
        check("R1 mid track", track, 1);
        check("R1 mid result", data_bus, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule